// File: doc/BRIEF.md
# I2C Write Target with High-Speed Entry

This block is the serial front end of a multi-channel programmable reference device. It oversamples SCL and SDA on a fast system clock and recognises START, repeated START and STOP. It accepts write transfers addressed to its own 7-bit address and passes each received data byte to the register side as a single-cycle strobe. SDA is driven only low, through an output-enable line, and SCL is never driven.

Beyond plain addressing, the block handles two special first bytes. The high-speed master code sets a mode flag, which stays set across repeated STARTs until the next STOP. The general-call address, when followed by the reset code, produces a one-cycle full-reset pulse. A general-call byte carrying any other value is refused.

Top module: `i2c_hs_target`

## Requirements
- R1: A first byte whose upper seven bits equal 111010 followed by the level of `addr_sel`, and whose bit 0 (read/write, 0 = write) is 0, is acknowledged by asserting `sda_oe` during the ninth SCL pulse. The same address with bit 0 = 1 is not acknowledged.
- R2: When the first byte matches none of the accepted values, SDA stays released. Every later byte of that transfer is then ignored: it gets no acknowledge, no `rx_valid` and no `gc_reset`, until the next START.
- R3: Each data byte after an acknowledged write address is received MSB first and acknowledged. It appears on `rx_data` together with a `rx_valid` pulse of exactly one cycle.
- R4: A START or repeated START at any point restarts the address phase. After a STOP, bytes sent without a new START are ignored.
- R5: A first byte of the form 00001xxx (any low three bits) is not acknowledged and sets `hs_mode`.
- R6: `hs_mode` stays set across repeated STARTs and their transfers, and is cleared by the next STOP.
- R7: The first byte 0x00 is always acknowledged. A following byte 0x06 is also acknowledged, and `gc_reset` then pulses high for exactly one cycle at the end of that acknowledge.
- R8: After 0x00, any byte other than 0x06 is not acknowledged and produces no `gc_reset` pulse.
- R9: After reset, `sda_oe`, `hs_mode`, `rx_valid` and `gc_reset` are all low.
- R10: `sda_oe` is only raised while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel | input | 1 | Selects the address LSB |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| rx_valid | output | 1 | One-cycle strobe for a received data byte |
| rx_data | output | 8 | Last received data byte |
| hs_mode | output | 1 | High-speed mode active |
| gc_reset | output | 1 | One-cycle full-reset request |

## Verification
A line change reaches the state register after at most four system clocks: two synchroniser flops, one edge-history flop and the state flop. `rx_valid`, `hs_mode` and the release of `sda_oe` therefore follow the SCL fall after bit 8 (or after the ack bit) within four clocks. `hs_mode` clears within four clocks of a STOP. The bench holds each bus phase for eight clocks and samples one cycle past an edge, well after each result is due. It reads the acknowledge on the wired SDA line midway through the ninth SCL high phase. It collects `rx_valid` and `gc_reset` pulses in monitors and compares them against the model once each byte completes.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_HOLD
  } tgt_state_e;

  typedef enum logic [1:0] {
    XF_ADDR,
    XF_WRITE,
    XF_GCALL,
    XF_GCRST
  } xfer_kind_e;

  localparam int unsigned BYTE_W = 8;
  localparam logic [7:0] GCALL_ADDR   = 8'h00;
  localparam logic [7:0] GCALL_RESET  = 8'h06;
  localparam logic [4:0] HS_CODE_HIGH = 5'b00001;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dsync,
  output logic [W-1:0] dprev
);
  logic [W-1:0] pipe [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k <= STAGES; k++) pipe[k] <= '1;
    end else begin
      pipe[0] <= din;
      for (int k = 1; k <= STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign dsync = pipe[STAGES-1];
  assign dprev = pipe[STAGES];
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic scl_s,
  input  logic scl_p,
  input  logic sda_s,
  input  logic sda_p,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_high;

  always_comb begin
    scl_high  = scl_s & scl_p;
    start_det = scl_high & sda_p & ~sda_s;
    stop_det  = scl_high & ~sda_p & sda_s;
    scl_rise  = scl_s & ~scl_p;
    scl_fall  = ~scl_s & scl_p;
  end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [5:0] ADDR_BASE = 6'b111010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              addr_sel,
  output logic              sda_oe,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              hs_mode,
  output logic              gc_reset
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  tgt_state_e        state, state_n;
  xfer_kind_e        kind, kind_n;
  logic [CNT_W-1:0]  bitcnt, bitcnt_n;
  logic [BYTE_W-1:0] shreg, shreg_n;
  logic [BYTE_W-1:0] data_n;
  logic              rxv_n, gcr_n, hs_n;
  logic              own_addr;

  assign own_addr = (shreg[7:1] == {ADDR_BASE, addr_sel}) && !shreg[0];

  always_comb begin
    state_n  = state;
    kind_n   = kind;
    bitcnt_n = bitcnt;
    shreg_n  = shreg;
    data_n   = rx_data;
    rxv_n    = 1'b0;
    gcr_n    = 1'b0;
    hs_n     = hs_mode;
    if (stop_det) begin
      state_n = ST_IDLE;
      hs_n    = 1'b0;
    end else if (start_det) begin
      state_n  = ST_RECV;
      kind_n   = XF_ADDR;
      bitcnt_n = '0;
    end else begin
      unique case (state)
        ST_RECV: begin
          if (scl_rise && bitcnt != CNT_FULL) begin
            shreg_n  = {shreg[BYTE_W-2:0], sda_s};
            bitcnt_n = bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == CNT_FULL) begin
            state_n = ST_HOLD;
            unique case (kind)
              XF_ADDR: begin
                if (own_addr) begin
                  state_n = ST_ACK;
                  kind_n  = XF_WRITE;
                end else if (shreg == GCALL_ADDR) begin
                  state_n = ST_ACK;
                  kind_n  = XF_GCALL;
                end else if (shreg[7:3] == HS_CODE_HIGH) begin
                  hs_n = 1'b1;
                end
              end
              XF_WRITE: begin
                state_n = ST_ACK;
                rxv_n   = 1'b1;
                data_n  = shreg;
              end
              XF_GCALL: begin
                if (shreg == GCALL_RESET) begin
                  state_n = ST_ACK;
                  kind_n  = XF_GCRST;
                end
              end
              default: ;
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt_n = '0;
            if (kind == XF_GCRST) begin
              gcr_n   = 1'b1;
              state_n = ST_HOLD;
            end else begin
              state_n = ST_RECV;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind     <= XF_ADDR;
      bitcnt   <= '0;
      shreg    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      gc_reset <= 1'b0;
      hs_mode  <= 1'b0;
    end else begin
      state    <= state_n;
      kind     <= kind_n;
      bitcnt   <= bitcnt_n;
      shreg    <= shreg_n;
      rx_valid <= rxv_n;
      gc_reset <= gcr_n;
      hs_mode  <= hs_n;
      if (rxv_n) rx_data <= data_n;
    end
  end

  assign sda_oe = (state == ST_ACK);

  AST_RXV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R3
  AST_GCR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset |=> !gc_reset); // R7
  AST_HS_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !hs_mode); // R6
  AST_MC_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> !sda_oe); // R5
  AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R10
  AST_COND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det)); // R4
endmodule

// File: rtl/i2c_hs_target.sv
module i2c_hs_target
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [5:0]  ADDR_BASE   = 6'b111010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel,
  output logic              sda_oe,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              hs_mode,
  output logic              gc_reset
);
  logic [1:0] line_s, line_p;
  logic       start_det, stop_det, scl_rise, scl_fall;

  i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({scl_i, sda_i}),
    .dsync (line_s),
    .dprev (line_p)
  );

  i2c_cond_det u_cond (
    .scl_s     (line_s[1]),
    .scl_p     (line_p[1]),
    .sda_s     (line_s[0]),
    .sda_p     (line_p[0]),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall)
  );

  i2c_tgt_fsm #(.ADDR_BASE(ADDR_BASE)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (line_s[1]),
    .sda_s     (line_s[0]),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .addr_sel  (addr_sel),
    .sda_oe    (sda_oe),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .hs_mode   (hs_mode),
    .gc_reset  (gc_reset)
  );
endmodule

// File: tb/sim_i2c_hs_target.sv
`timescale 1ns/1ps
module sim_i2c_hs_target;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic sda_oe, rx_valid, hs_mode, gc_reset;
  logic [7:0] rx_data;
  logic sda_line;

  int vec = 0;
  int err = 0;
  int rx_cnt = 0;
  int gc_cnt = 0;
  logic [7:0] rx_last = 8'h00;
  bit done = 0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_hs_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .rx_valid(rx_valid),
    .rx_data(rx_data), .hs_mode(hs_mode), .gc_reset(gc_reset)
  );

  always @(posedge clk) begin
    if (rx_valid) begin rx_cnt <= rx_cnt + 1; rx_last <= rx_data; end
    if (gc_reset) gc_cnt <= gc_cnt + 1;
  end

  task automatic chk(string req, int act, int exp);
    vec++;
    if (act != exp) begin
      err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = !sda_line;
    wq(); scl_m = 1'b0; wq();
  endtask

  function automatic bit exp_addr_ack(logic [7:0] b, logic sel);
    return (b[7:1] == {6'b111010, sel}) && !b[0];
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vec++; err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vec, err);
      $finish;
    end
  end

  initial begin
    bit ack;
    int r0, g0;
    void'($urandom(32'd2718));
    repeat (4) @(posedge clk); #1;
    // R9 reset state
    chk("R9 sda_oe", sda_oe, 0);
    chk("R9 hs_mode", hs_mode, 0);
    chk("R9 rx_valid", rx_valid, 0);
    chk("R9 gc_reset", gc_reset, 0);
    rst_n = 1'b1;
    wq();

    // R1 / R3 write to 0x74
    addr_sel = 1'b0;
    bus_start();
    send_byte(8'hE8, ack); chk("R1 addr 0x74 ack", ack, 1);
    r0 = rx_cnt;
    send_byte(8'hA5, ack); chk("R3 data ack", ack, 1);
    chk("R3 data value", rx_last, 8'hA5);
    send_byte(8'h3C, ack); chk("R3 second value", rx_last, 8'h3C);
    chk("R3 strobe count", rx_cnt - r0, 2);
    bus_stop();

    // R1 read bit refused
    bus_start();
    send_byte(8'hE9, ack); chk("R1 read not acked", ack, 0);
    bus_stop();

    // R2 mismatch with addr_sel high, subsequent bytes ignored
    addr_sel = 1'b1;
    bus_start();
    r0 = rx_cnt; g0 = gc_cnt;
    send_byte(8'hE8, ack); chk("R2 wrong addr nack", ack, 0);
    send_byte(8'h00, ack); chk("R2 later byte nack", ack, 0);
    send_byte(8'h06, ack); chk("R2 later byte nack2", ack, 0);
    chk("R2 no rx", rx_cnt - r0, 0);
    chk("R2 no gc", gc_cnt - g0, 0);
    // R4 repeated start recovers
    bus_start();
    send_byte(8'hEA, ack); chk("R4 rstart addr ack", ack, 1);
    send_byte(8'h5A, ack); chk("R4 data after rstart", rx_last, 8'h5A);
    bus_stop();
    r0 = rx_cnt;
    send_byte(8'hEA, ack); chk("R4 no start after stop", ack, 0);
    chk("R4 no rx after stop", rx_cnt - r0, 0);
    bus_stop();

    // R5 / R6 high-speed entry
    bus_start();
    send_byte(8'h0D, ack); chk("R5 master code nack", ack, 0);
    chk("R5 hs set", hs_mode, 1);
    bus_start();
    chk("R6 hs across rstart", hs_mode, 1);
    send_byte(8'hEA, ack); chk("R6 addr ack in hs", ack, 1);
    send_byte(8'h77, ack); chk("R6 data in hs", rx_last, 8'h77);
    chk("R6 hs still set", hs_mode, 1);
    bus_stop();
    chk("R6 hs cleared", hs_mode, 0);

    // R7 general-call reset
    bus_start();
    g0 = gc_cnt;
    send_byte(8'h00, ack); chk("R7 gcall addr ack", ack, 1);
    send_byte(8'h06, ack); chk("R7 reset code ack", ack, 1);
    chk("R7 single pulse", gc_cnt - g0, 1);
    bus_stop();
    // R8 other code
    bus_start();
    g0 = gc_cnt;
    send_byte(8'h00, ack); chk("R8 gcall addr ack", ack, 1);
    send_byte(8'h07, ack); chk("R8 other code nack", ack, 0);
    chk("R8 no pulse", gc_cnt - g0, 0);
    bus_stop();

    // random traffic (R1 R2 R3)
    for (int it = 0; it < 40; it++) begin
      logic [7:0] a;
      bit ea;
      int nb;
      addr_sel = 1'($urandom % 2);
      if ($urandom % 2) a = {6'b111010, 1'($urandom % 2), 1'b0};
      else a = 8'($urandom);
      if (a[7:3] == 5'b0) a[7] = 1'b1;
      ea = exp_addr_ack(a, addr_sel);
      nb = 1 + int'($urandom % 3);
      bus_start();
      send_byte(a, ack); chk("R1 random addr ack", ack, ea);
      for (int j = 0; j < nb; j++) begin
        logic [7:0] d;
        d = 8'($urandom);
        r0 = rx_cnt;
        send_byte(d, ack);
        chk("R2 random data ack", ack, ea);
        chk("R3 random strobe", rx_cnt - r0, ea ? 1 : 0);
        if (ea) chk("R3 random data", rx_last, d);
      end
      bus_stop();
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end
endmodule